// File: doc/BRIEF.md
# Address Region Access Guard

The guard screens every memory access against a small bank of programmable address windows. Each window has a lower bound, an upper bound, an enable bit and one of three permission levels: no access, read only, or read and write. An access that lands in an enabled window whose permission covers the access type is allowed. Any other access is refused and reported as a fault.

Software programs the windows through a simple register write port. It can rewrite them at any time, for example when switching from one task to the next. The allow decision is combinational within the request cycle. The fault flag and the offending address are registered on the clock edge that ends the request cycle. When windows overlap, the window with the highest index decides.

Top module: `addr_guard`

## Requirements
- R1: After reset every window is disabled, so any valid request is refused. `fault_o` reads 0 and `fault_addr_o` reads 0 until the first refused request.
- R2: A window matches when its enable bit (`cfg_wdata[0]` of a control write) is 1 and base <= address <= limit, with both bounds inclusive. Clearing the enable bit removes the match.
- R3: A matching window with permission code 2'b00 (none) refuses both reads and writes.
- R4: A matching window with permission code 2'b01 (read only) allows reads (`req_write`=0) and refuses writes (`req_write`=1).
- R5: A matching window with permission code 2'b10 (read and write) allows both reads and writes.
- R6: When several windows match, only the highest-index matching window decides, even when it is more restrictive than a lower one.
- R7: A valid request that matches no window is refused.
- R8: `fault_o` is high for exactly the cycle after a refused valid request, and `fault_addr_o` then holds that request's address. `fault_addr_o` keeps its value until the next refused request.
- R9: With `req_valid` low, `allow_o` is 0 and no fault is raised on the next cycle.
- R10: A configuration write takes effect from the following cycle. A request in the same cycle as the write is judged against the old settings.
- R11: A window whose base is above its limit matches no address.
- R12: Permission code 2'b11 is treated as no access.
- R13: Configuration writes use field select 0 for base, 1 for limit and 2 for control, with control bits [2:1] holding the permission. Field select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Window index to write |
| cfg_field | input | 2 | Field select: 0 base, 1 limit, 2 control |
| cfg_wdata | input | ADDR_W | Write data (control: bit 0 enable, bits 2:1 permission) |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| allow_o | output | 1 | Request allowed (combinational) |
| fault_o | output | 1 | Refused request in previous cycle |
| fault_addr_o | output | ADDR_W | Address of the latest refused request |

## Verification
A configuration write and an access can land in the same cycle. Both can also target the same window. The bench first loads the bounds of a disabled window. It then issues the write that enables the window in the same cycle as a read inside it. That read must be refused and must latch a fault. An identical read one cycle later must be allowed, which shows that the write took effect only after the clock edge.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b10,
    PERM_RSVD = 2'b11
  } perm_e;

  localparam logic [1:0] FLD_BASE  = 2'd0;
  localparam logic [1:0] FLD_LIMIT = 2'd1;
  localparam logic [1:0] FLD_CTRL  = 2'd2;
endpackage

// File: rtl/addr_guard_cfg.sv
module addr_guard_cfg
  import addr_guard_pkg::*;
#(
  parameter int N_WIN  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              idx,
  input  logic [1:0]                    field,
  input  logic [ADDR_W-1:0]             wdata,
  output logic [N_WIN-1:0][ADDR_W-1:0]  base_o,
  output logic [N_WIN-1:0][ADDR_W-1:0]  limit_o,
  output logic [N_WIN-1:0]              en_o,
  output perm_e [N_WIN-1:0]             perm_o
);
  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    logic sel;
    assign sel = we && (idx == IDX_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[w]  <= '0;
        limit_o[w] <= '0;
        en_o[w]    <= 1'b0;
        perm_o[w]  <= PERM_NONE;
      end else if (sel) begin
        case (field)
          FLD_BASE:  base_o[w]  <= wdata;
          FLD_LIMIT: limit_o[w] <= wdata;
          FLD_CTRL: begin
            en_o[w]   <= wdata[0];
            perm_o[w] <= perm_e'(wdata[2:1]);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/addr_guard_match.sv
module addr_guard_match
  import addr_guard_pkg::*;
#(
  parameter int N_WIN  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [N_WIN-1:0][ADDR_W-1:0] base_i,
  input  logic [N_WIN-1:0][ADDR_W-1:0] limit_i,
  input  logic [N_WIN-1:0]             en_i,
  input  perm_e [N_WIN-1:0]            perm_i,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         is_write,
  output logic                         grant
);
  logic [N_WIN-1:0] hit;

  for (genvar w = 0; w < N_WIN; w++) begin : g_cmp
    assign hit[w] = en_i[w] && (addr >= base_i[w]) && (addr <= limit_i[w]);
  end

  perm_e win_perm;
  logic  any_hit;

  // Ascending scan: a later (higher index) hit overrides earlier ones.
  always_comb begin
    win_perm = PERM_NONE;
    any_hit  = 1'b0;
    for (int w = 0; w < N_WIN; w++) begin
      if (hit[w]) begin
        win_perm = perm_i[w];
        any_hit  = 1'b1;
      end
    end
  end

  always_comb begin
    grant = 1'b0;
    if (any_hit) begin
      unique case (win_perm)
        PERM_RW:  grant = 1'b1;
        PERM_RO:  grant = !is_write;
        default:  grant = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/addr_guard.sv
module addr_guard
  import addr_guard_pkg::*;
#(
  parameter int N_WIN  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              allow_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  logic [N_WIN-1:0][ADDR_W-1:0] base_q;
  logic [N_WIN-1:0][ADDR_W-1:0] limit_q;
  logic [N_WIN-1:0]             en_q;
  perm_e [N_WIN-1:0]            perm_q;
  logic                         grant;

  addr_guard_cfg #(.N_WIN(N_WIN), .ADDR_W(ADDR_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .idx     (cfg_idx),
    .field   (cfg_field),
    .wdata   (cfg_wdata),
    .base_o  (base_q),
    .limit_o (limit_q),
    .en_o    (en_q),
    .perm_o  (perm_q)
  );

  addr_guard_match #(.N_WIN(N_WIN), .ADDR_W(ADDR_W)) u_match (
    .base_i   (base_q),
    .limit_i  (limit_q),
    .en_i     (en_q),
    .perm_i   (perm_q),
    .addr     (req_addr),
    .is_write (req_write),
    .grant    (grant)
  );

  assign allow_o = req_valid && grant;

  logic refuse;
  assign refuse = req_valid && !grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      fault_o <= refuse;
      if (refuse) fault_addr_o <= req_addr;
    end
  end
endmodule

// File: rtl/addr_guard_chk.sv
module addr_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              allow_o,
  input logic              fault_o,
  input logic [ADDR_W-1:0] fault_addr_o
);
  logic cfg_seen;
  always_ff @(posedge clk) begin
    if (rst) cfg_seen <= 1'b0;
    else if (cfg_we) cfg_seen <= 1'b1;
  end

  p_no_grant_unconfigured_r1: assert property (@(posedge clk) disable iff (rst)
    (!cfg_seen && req_valid) |-> !allow_o);

  p_fault_follows_refusal_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !allow_o) |=> (fault_o && fault_addr_o == $past(req_addr)));

  p_no_fault_after_allow_r8: assert property (@(posedge clk) disable iff (rst)
    allow_o |=> !fault_o);

  p_addr_held_r8: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !allow_o) |=> $stable(fault_addr_o));

  p_idle_no_allow_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !allow_o);

  p_idle_no_fault_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !fault_o);
endmodule

bind addr_guard addr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .allow_o      (allow_o),
  .fault_o      (fault_o),
  .fault_addr_o (fault_addr_o)
);

// File: tb/addr_guard_tb.sv
module addr_guard_tb;
  localparam int N_WIN  = 8;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [IDX_W-1:0]  cfg_idx = '0;
  logic [1:0]        cfg_field = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              allow_o;
  logic              fault_o;
  logic [ADDR_W-1:0] fault_addr_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  addr_guard #(.N_WIN(N_WIN), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .allow_o(allow_o),
    .fault_o(fault_o), .fault_addr_o(fault_addr_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [1:0] fld, input logic [ADDR_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // ctrl word: bit0 enable, bits 2:1 permission
  task automatic win(input int idx, input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] l,
                     input logic en, input logic [1:0] perm);
    wr(idx, 2'd0, b);
    wr(idx, 2'd1, l);
    wr(idx, 2'd2, {29'd0, perm, en});
  endtask

  // One request; checks allow in-cycle, then fault/addr in the following cycle.
  task automatic acc(input string tag, input logic [ADDR_W-1:0] a, input logic w, input logic exp_allow);
    logic [ADDR_W-1:0] prev_fa;
    @(negedge clk);
    prev_fa = fault_addr_o;
    req_valid = 1'b1; req_addr = a; req_write = w;
    #1;
    chk({tag, " allow"}, 64'(allow_o), 64'(exp_allow));
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " fault"}, 64'(fault_o), 64'(!exp_allow));
    chk({tag, " faddr"}, 64'(fault_addr_o), 64'(exp_allow ? prev_fa : a));
  endtask

  task automatic t_reset();
    chk("R1 fault after reset", 64'(fault_o), 64'd0);
    chk("R1 faddr after reset", 64'(fault_addr_o), 64'd0);
    acc("R1 R7 unconfigured read", 32'h100, 1'b0, 1'b0);
  endtask

  task automatic t_bounds();
    win(0, 32'h1000, 32'h1FFF, 1'b1, 2'b10);
    acc("R2 base", 32'h1000, 1'b0, 1'b1);
    acc("R2 limit", 32'h1FFF, 1'b0, 1'b1);
    acc("R2 R7 below", 32'h0FFF, 1'b0, 1'b0);
    acc("R2 R7 above", 32'h2000, 1'b0, 1'b0);
  endtask

  task automatic t_perms();
    win(1, 32'h3000, 32'h3FFF, 1'b1, 2'b01);
    acc("R4 ro read", 32'h3010, 1'b0, 1'b1);
    acc("R4 ro write", 32'h3020, 1'b1, 1'b0);
    win(2, 32'h4000, 32'h4FFF, 1'b1, 2'b00);
    acc("R3 none read", 32'h4000, 1'b0, 1'b0);
    acc("R3 none write", 32'h4004, 1'b1, 1'b0);
    acc("R5 rw write", 32'h1234, 1'b1, 1'b1);
    win(3, 32'h5000, 32'h5FFF, 1'b1, 2'b11);
    acc("R12 code3 read", 32'h5000, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    win(5, 32'h1800, 32'h18FF, 1'b1, 2'b01);
    acc("R6 higher ro wins", 32'h1810, 1'b1, 1'b0);
    acc("R6 outside overlap", 32'h1700, 1'b1, 1'b1);
    win(6, 32'h1800, 32'h180F, 1'b1, 2'b10);
    acc("R6 highest rw wins", 32'h1805, 1'b1, 1'b1);
  endtask

  task automatic t_idle();
    logic [ADDR_W-1:0] fa;
    @(negedge clk);
    fa = fault_addr_o;
    req_valid = 1'b0; req_addr = 32'hDEAD0000; req_write = 1'b1;
    #1;
    chk("R9 idle allow", 64'(allow_o), 64'd0);
    @(negedge clk);
    chk("R9 idle fault", 64'(fault_o), 64'd0);
    chk("R8 faddr held", 64'(fault_addr_o), 64'(fa));
  endtask

  task automatic t_same_cycle();
    wr(4, 2'd0, 32'h6000);
    wr(4, 2'd1, 32'h6FFF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd4; cfg_field = 2'd2; cfg_wdata = 32'h5; // enable, rw
    req_valid = 1'b1; req_addr = 32'h6100; req_write = 1'b0;
    #1;
    chk("R10 same-cycle allow", 64'(allow_o), 64'd0);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R10 same-cycle fault", 64'(fault_o), 64'd1);
    chk("R10 same-cycle faddr", 64'(fault_addr_o), 64'h6100);
    acc("R10 next cycle", 32'h6100, 1'b0, 1'b1);
  endtask

  task automatic t_disable_and_field3();
    wr(4, 2'd3, 32'h0);
    acc("R13 field3 no effect", 32'h6200, 1'b0, 1'b1);
    wr(4, 2'd2, 32'h4); // rw, enable cleared
    acc("R2 disabled", 32'h6200, 1'b0, 1'b0);
  endtask

  task automatic t_inverted();
    win(7, 32'h9000, 32'h8000, 1'b1, 2'b10);
    acc("R11 inverted mid", 32'h8800, 1'b0, 1'b0);
    acc("R11 inverted base", 32'h9000, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bounds();
    t_perms();
    t_priority();
    t_idle();
    t_same_cycle();
    t_disable_and_field3();
    t_inverted();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule